// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is one 8-bit control and status register of a small microcontroller. It holds a run enable and an overflow flag for each of two timers. It also holds an event flag and a trigger-mode select for each of two external interrupt lines. The CPU reaches the register in two ways: through a byte port at one register address, or through a single-bit port in a bit-addressable space, where each bit of the register has its own bit address.

Hardware sets the flags from timer overflow pulses and from the external lines. The external lines arrive already normalised to active-high. Software clears a flag by writing it. A flag also clears when the CPU acknowledges a vector to its handler. For an external line, that acknowledge clear applies only in edge mode. Each flag drives an interrupt request output directly. The timer counters, the line polarity selection and the interrupt priority are outside this block.

Top module: `tmr_xint_ctl`

## Requirements
- R1: While `rst_n` is low, every register bit is 0, so `rd_data`, `tmr_run`, `tmr_irq` and `xint_irq` are all 0.
- R2: A byte write (`byte_we`) with `byte_addr` equal to 0x88 loads all eight bits from `byte_data` at the next clock edge, subject to R6 and R8. A byte write to any other address changes nothing.
- R3: A bit write (`bit_we`) with `bit_addr` from 0x88 to 0x8F loads `bit_val` into bit `bit_addr - 0x88` only. A bit write outside that range changes nothing. When a byte write and a bit write hit the same bit in one cycle, the bit write decides that bit.
- R4: `tmr_run[1]` and `tmr_run[0]` equal register bits 6 and 4. Only writes change them.
- R5: A pulse on `tmr_ovf[n]` sets timer flag n (bit 5 for timer 0, bit 7 for timer 1) at the next edge. Writing 0 clears the flag. `tmr_ack[n]` clears it when no write hits the flag in that cycle.
- R6: When a timer overflow pulse coincides with a write of 0 or an acknowledge, the flag is still set afterwards.
- R7: With mode bit 1 for line n (bit 0 for line 0, bit 2 for line 1), flag n (bit 1 or bit 3) is set by a low-to-high change of `xint_in[n]` between two clock edges. A held high level sets it only once. `xint_ack[n]` or a write of 0 clears it, and an edge in the same cycle wins over the clear.
- R8: With mode bit 0 for line n, flag n equals the value of `xint_in[n]` at the previous edge. Writes and `xint_ack[n]` have no effect on it.
- R9: `tmr_irq[n]` equals timer flag n and `xint_irq[n]` equals external flag n.
- R10: `rd_data` bits 7 down to 0 read: timer 1 flag, timer 1 run, timer 0 flag, timer 0 run, line 1 flag, line 1 mode, line 0 flag, line 0 mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_we | input | 1 | Byte write strobe |
| byte_addr | input | 8 | Byte write address |
| byte_data | input | 8 | Byte write data |
| bit_we | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address in the bit-addressable space |
| bit_val | input | 1 | Single-bit write value |
| tmr_ovf | input | 2 | Timer overflow pulses, one per timer |
| tmr_ack | input | 2 | CPU vector acknowledge, one per timer |
| xint_in | input | 2 | External interrupt lines, active-high |
| xint_ack | input | 2 | CPU vector acknowledge, one per external line |
| rd_data | output | 8 | Register readback |
| tmr_run | output | 2 | Timer run enables |
| tmr_irq | output | 2 | Timer interrupt requests |
| xint_irq | output | 2 | External interrupt requests |

## Verification
A flag's hardware set can land in the same cycle as one of its clears. The clear is either a software write of 0 or a vector acknowledge. The bench provokes this with directed cycles that drive an overflow pulse together with an acknowledge, and an overflow pulse together with a bit write of 0. It also drives a rising external line together with an acknowledge in edge mode. In every case the flag must read 1 in the following cycle. A long random phase draws writes, pulses, acknowledges and line changes independently, so these collisions recur in both line modes. A behavioural model that applies set-over-clear judges each collision cycle by cycle.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;

  // Bit positions inside the register, as a function of the channel count.
  function automatic int tf_pos(int nch, int n);
    return 2*nch + 2*n + 1;
  endfunction

  function automatic int tr_pos(int nch, int n);
    return 2*nch + 2*n;
  endfunction

  function automatic int xf_pos(int n);
    return 2*n + 1;
  endfunction

  function automatic int xt_pos(int n);
    return 2*n;
  endfunction

  // Next value of a sticky flag: a hardware set beats a write,
  // and a write beats an acknowledge clear.
  function automatic logic sticky_next(logic set, logic hit, logic val,
                                       logic clr, logic cur);
    if (set)      return 1'b1;
    else if (hit) return val;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/tcr_wr_decode.sv
module tcr_wr_decode #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h88
) (
  input  logic              byte_we,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              bit_we,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_val,
  output logic [DATA_W-1:0] wr_hit,
  output logic [DATA_W-1:0] wr_val
);
  localparam int IDX_W = $clog2(DATA_W);

  logic byte_sel;
  logic bit_sel;
  logic [IDX_W-1:0] bit_idx;

  assign byte_sel = byte_we && (byte_addr == REG_ADDR);
  assign bit_sel  = bit_we && (bit_addr[ADDR_W-1:IDX_W] == REG_ADDR[ADDR_W-1:IDX_W]);
  assign bit_idx  = bit_addr[IDX_W-1:0];

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic bit_here;
    assign bit_here  = bit_sel && (bit_idx == IDX_W'(b));
    assign wr_hit[b] = byte_sel || bit_here;
    assign wr_val[b] = bit_here ? bit_val : byte_data[b];
  end

endmodule

// File: rtl/tovf_flag.sv
module tovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic ack,
  input  logic wr_hit,
  input  logic wr_val,
  output logic flag_q
);
  import tmr_xint_pkg::*;

  logic flag_d;

  always_comb flag_d = sticky_next(ovf, wr_hit, wr_val, ack, flag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/xint_flag.sv
module xint_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic edge_mode,
  input  logic ack,
  input  logic wr_hit,
  input  logic wr_val,
  output logic flag_q,
  output logic line_d_q
);
  import tmr_xint_pkg::*;

  logic rise_evt;
  logic flag_d;

  assign rise_evt = line_in && !line_d_q;

  always_comb begin
    if (edge_mode) flag_d = sticky_next(rise_evt, wr_hit, wr_val, ack, flag_q);
    else           flag_d = line_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      line_d_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      line_d_q <= line_in;
    end
  end

endmodule

// File: rtl/tmr_xint_ctl.sv
module tmr_xint_ctl #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h88,
  localparam int DATA_W = 4*NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              bit_we,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_val,
  input  logic [NUM_CH-1:0] tmr_ovf,
  input  logic [NUM_CH-1:0] tmr_ack,
  input  logic [NUM_CH-1:0] xint_in,
  input  logic [NUM_CH-1:0] xint_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] tmr_run,
  output logic [NUM_CH-1:0] tmr_irq,
  output logic [NUM_CH-1:0] xint_irq
);
  import tmr_xint_pkg::*;

  logic [DATA_W-1:0] wr_hit;
  logic [DATA_W-1:0] wr_val;
  logic [NUM_CH-1:0] xin_d;
  logic [NUM_CH-1:0] run_q;
  logic [NUM_CH-1:0] mode_q;
  logic [NUM_CH-1:0] tflag;
  logic [NUM_CH-1:0] xflag;

  tcr_wr_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR)
  ) u_dec (
    .byte_we  (byte_we),
    .byte_addr(byte_addr),
    .byte_data(byte_data),
    .bit_we   (bit_we),
    .bit_addr (bit_addr),
    .bit_val  (bit_val),
    .wr_hit   (wr_hit),
    .wr_val   (wr_val)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int TF = tf_pos(NUM_CH, n);
    localparam int TR = tr_pos(NUM_CH, n);
    localparam int XF = xf_pos(n);
    localparam int XT = xt_pos(n);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q[n]  <= 1'b0;
        mode_q[n] <= 1'b0;
      end else begin
        if (wr_hit[TR]) run_q[n]  <= wr_val[TR];
        if (wr_hit[XT]) mode_q[n] <= wr_val[XT];
      end
    end

    tovf_flag u_tf (
      .clk   (clk),
      .rst_n (rst_n),
      .ovf   (tmr_ovf[n]),
      .ack   (tmr_ack[n]),
      .wr_hit(wr_hit[TF]),
      .wr_val(wr_val[TF]),
      .flag_q(tflag[n])
    );

    xint_flag u_xf (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (xint_in[n]),
      .edge_mode(mode_q[n]),
      .ack      (xint_ack[n]),
      .wr_hit   (wr_hit[XF]),
      .wr_val   (wr_val[XF]),
      .flag_q   (xflag[n]),
      .line_d_q (xin_d[n])
    );

    assign rd_data[TF] = tflag[n];
    assign rd_data[TR] = run_q[n];
    assign rd_data[XF] = xflag[n];
    assign rd_data[XT] = mode_q[n];
  end

  assign tmr_run  = run_q;
  assign tmr_irq  = tflag;
  assign xint_irq = xflag;

endmodule

// File: rtl/tmr_xint_ctl_chk.sv
module tmr_xint_ctl_chk #(
  parameter int NUM_CH = 2,
  localparam int DATA_W = 4*NUM_CH
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] tmr_ovf,
  input logic [NUM_CH-1:0] tmr_ack,
  input logic [NUM_CH-1:0] xint_in,
  input logic [NUM_CH-1:0] xint_ack,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] wr_hit,
  input logic [NUM_CH-1:0] xin_d
);
  import tmr_xint_pkg::*;

  // R1: the cycle after reset is seen active, the register reads zero
  p_reset_r1: assert property (@(posedge clk) !rst_n |=> rd_data == '0);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    localparam int TF = tf_pos(NUM_CH, n);
    localparam int TR = tr_pos(NUM_CH, n);
    localparam int XF = xf_pos(n);
    localparam int XT = xt_pos(n);

    p_run_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[TR] |=> rd_data[TR] == $past(rd_data[TR]));

    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[XT] |=> rd_data[XT] == $past(rd_data[XT]));

    p_ovf_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf[n] |=> rd_data[TF]);

    p_hw_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_ovf[n] && (tmr_ack[n] || wr_hit[TF])) |=> rd_data[TF]);

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[TF] && tmr_ack[n] && !tmr_ovf[n] && !wr_hit[TF]) |=> !rd_data[TF]);

    p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[XT] && xint_in[n] && !xin_d[n]) |=> rd_data[XF]);

    p_edge_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[XT] && xin_d[n] && !rd_data[XF] && !wr_hit[XF]) |=> !rd_data[XF]);

    p_xack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[XT] && xint_ack[n] && !(xint_in[n] && !xin_d[n]) && !wr_hit[XF])
      |=> !rd_data[XF]);

    p_level_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[XT] |=> rd_data[XF] == $past(xint_in[n]));
  end

endmodule

bind tmr_xint_ctl tmr_xint_ctl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tmr_ovf (tmr_ovf),
  .tmr_ack (tmr_ack),
  .xint_in (xint_in),
  .xint_ack(xint_ack),
  .rd_data (rd_data),
  .wr_hit  (wr_hit),
  .xin_d   (xin_d)
);

// File: tb/tmr_xint_ctl_test.sv
`timescale 1ns/1ps
module tmr_xint_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_we = 1'b0;
  logic [7:0] byte_addr = '0;
  logic [7:0] byte_data = '0;
  logic       bit_we = 1'b0;
  logic [7:0] bit_addr = '0;
  logic       bit_val = 1'b0;
  logic [1:0] tmr_ovf = '0, tmr_ack = '0, xint_in = '0, xint_ack = '0;
  logic [7:0] rd_data;
  logic [1:0] tmr_run, tmr_irq, xint_irq;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // behavioural model: one bit per register position, plus last line sample
  bit m[8];
  bit m_prev[2];

  always #10 clk = ~clk;

  tmr_xint_ctl uut (
    .clk(clk), .rst_n(rst_n),
    .byte_we(byte_we), .byte_addr(byte_addr), .byte_data(byte_data),
    .bit_we(bit_we), .bit_addr(bit_addr), .bit_val(bit_val),
    .tmr_ovf(tmr_ovf), .tmr_ack(tmr_ack), .xint_in(xint_in), .xint_ack(xint_ack),
    .rd_data(rd_data), .tmr_run(tmr_run), .tmr_irq(tmr_irq), .xint_irq(xint_irq)
  );

  function automatic logic [7:0] model_byte();
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = m[b];
    return r;
  endfunction

  // advance the model by one clock with the inputs now driven
  task automatic model_step();
    bit hit[8];
    bit val[8];
    bit nm[8];
    for (int b = 0; b < 8; b++) begin
      bit by  = byte_we && byte_addr == 8'h88;
      bit bi  = bit_we && int'(bit_addr) == 136 + b;
      hit[b]  = by || bi;
      val[b]  = bi ? bit_val : byte_data[b];
      nm[b]   = m[b];
    end
    for (int n = 0; n < 2; n++) begin
      int tf = 5 + 2*n, tr = 4 + 2*n, xf = 1 + 2*n, xt = 2*n;
      if (hit[tr]) nm[tr] = val[tr];
      if (hit[xt]) nm[xt] = val[xt];
      if (tmr_ovf[n])      nm[tf] = 1;
      else if (hit[tf])    nm[tf] = val[tf];
      else if (tmr_ack[n]) nm[tf] = 0;
      if (m[xt] == 0) nm[xf] = xint_in[n];
      else if (xint_in[n] && !m_prev[n]) nm[xf] = 1;
      else if (hit[xf])     nm[xf] = val[xf];
      else if (xint_ack[n]) nm[xf] = 0;
      m_prev[n] = xint_in[n];
    end
    for (int b = 0; b < 8; b++) m[b] = nm[b];
  endtask

  task automatic compare(string tag);
    logic [7:0] e = model_byte();
    logic [1:0] er = {e[6], e[4]}, et = {e[7], e[5]}, ex = {e[3], e[1]};
    total++;
    if (rd_data !== e || tmr_run !== er || tmr_irq !== et || xint_irq !== ex) begin
      fails++;
      $display("FAIL %s: rd=%h run=%b tirq=%b xirq=%b expected rd=%h run=%b tirq=%b xirq=%b",
               tag, rd_data, tmr_run, tmr_irq, xint_irq, e, er, et, ex);
    end
  endtask

  task automatic check8(logic [7:0] act, logic [7:0] exp, string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: inputs are already driven at a falling edge
  task automatic cyc(string tag);
    model_step();
    @(negedge clk);
    compare(tag);
    byte_we = 0; bit_we = 0; tmr_ovf = '0; tmr_ack = '0; xint_ack = '0;
  endtask

  task automatic wbyte(logic [7:0] a, logic [7:0] d);
    byte_we = 1; byte_addr = a; byte_data = d;
  endtask

  task automatic wbit(logic [7:0] a, logic v);
    bit_we = 1; bit_addr = a; bit_val = v;
  endtask

  initial begin
    for (int b = 0; b < 8; b++) m[b] = 0;
    m_prev[0] = 0; m_prev[1] = 0;
    repeat (3) @(negedge clk);
    check8(rd_data, 8'h00, "R1 reset readback");
    check8({tmr_run, tmr_irq, xint_irq}, 6'h0, "R1 reset outputs");
    rst_n = 1;

    wbyte(8'h88, 8'h55); cyc("R2 byte write");
    check8(rd_data, 8'h55, "R2/R10 byte write value");
    check8({6'h0, tmr_run}, 8'h03, "R4 run enables");
    wbyte(8'h89, 8'hFF); cyc("R2 other address");
    check8(rd_data, 8'h55, "R2 other address ignored");

    wbit(8'h8E, 0); cyc("R3 bit write");
    check8(rd_data, 8'h15, "R3 single bit cleared");
    wbit(8'h96, 1); cyc("R3 bit outside");
    check8(rd_data, 8'h15, "R3 bit address outside ignored");
    wbyte(8'h88, 8'h15); wbit(8'h8C, 1); cyc("R3 bit over byte");
    check8(rd_data, 8'h15, "R3 bit write beats byte write");
    wbyte(8'h88, 8'h05); wbit(8'h8C, 1); cyc("R3 bit over byte 2");
    check8(rd_data, 8'h15, "R3 bit write keeps run bit");

    tmr_ovf = 2'b01; cyc("R5 overflow");
    check8(rd_data, 8'h35, "R5 overflow sets flag");
    check8({6'h0, tmr_irq}, 8'h01, "R9 timer irq");
    tmr_ack = 2'b01; cyc("R5 ack");
    check8(rd_data, 8'h15, "R5 ack clears flag");
    tmr_ovf = 2'b01; tmr_ack = 2'b01; cyc("R6 ovf+ack");
    check8(rd_data, 8'h35, "R6 set wins over ack");
    tmr_ovf = 2'b01; wbit(8'h8D, 0); cyc("R6 ovf+write");
    check8(rd_data, 8'h35, "R6 set wins over write");
    wbit(8'h8D, 0); cyc("R5 sw clear");
    check8(rd_data, 8'h15, "R5 software clear");

    xint_in = 2'b01; cyc("R7 rise");
    check8(rd_data, 8'h17, "R7 edge sets flag");
    check8({6'h0, xint_irq}, 8'h01, "R9 ext irq");
    cyc("R7 hold");
    xint_ack = 2'b01; cyc("R7 ack");
    check8(rd_data, 8'h15, "R7 ack clears in edge mode");
    cyc("R7 held level");
    check8(rd_data, 8'h15, "R7 held level sets only once");
    xint_in = 2'b00; cyc("R7 fall");
    xint_in = 2'b01; xint_ack = 2'b01; cyc("R7 rise+ack");
    check8(rd_data, 8'h17, "R7 edge wins over ack");
    xint_ack = 2'b01; cyc("R7 ack2");

    xint_in = 2'b00; wbit(8'h8A, 0); cyc("R8 level mode");
    check8(rd_data, 8'h11, "R8 select level mode");
    xint_in = 2'b10; cyc("R8 active");
    check8(rd_data, 8'h19, "R8 flag follows line");
    wbyte(8'h88, 8'h11); cyc("R8 write");
    check8(rd_data, 8'h19, "R8 write cannot clear");
    xint_ack = 2'b10; cyc("R8 ack");
    check8(rd_data, 8'h19, "R8 ack has no effect");
    xint_in = 2'b00; cyc("R8 inactive");
    check8(rd_data, 8'h11, "R8 flag drops with line");

    // random phase: collisions of sets and clears in both modes
    for (int i = 0; i < 3000; i++) begin
      byte_we   = ($urandom % 8) == 0;
      byte_addr = ($urandom % 4 == 0) ? 8'($urandom) : 8'h88;
      byte_data = 8'($urandom);
      bit_we    = ($urandom % 3) == 0;
      bit_addr  = ($urandom % 4 == 0) ? 8'($urandom) : 8'(136 + $urandom % 8);
      bit_val   = 1'($urandom);
      tmr_ovf   = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      tmr_ack   = 2'($urandom);
      xint_ack  = 2'($urandom);
      if ($urandom % 3 == 0) xint_in = 2'($urandom);
      cyc("random R2 R3 R5 R6 R7 R8 R10");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule